// File: doc/BRIEF.md
# Serial Register Access Port

This block is the slave end of a four-wire serial control link through which an external host reads and writes a bank of byte-wide configuration registers. The host frames each access with an active-low select. It toggles a serial clock and sets a direction line. Data moves on one shared data wire, which the block splits into an input, an output and an output-enable for the pad.

The whole block runs on a fast master clock. The serial clock is not used as a clock: every serial input passes through a multi-stage synchronizer and the serial clock edges are detected in the master domain. For this reason the serial clock may run at no more than half the master clock rate.

A transfer has sixteen bits. The first eight are the register address and the last eight are the data, both most significant bit first. The block holds 2^ADDR_W registers. No reset touches them, so their contents survive resets and change only through write transfers.

Top module: `sregp_top`

## Requirements
- R1: A transfer is ADDR_W address bits followed by DATA_W data bits (8 and 8 by default), each field most significant bit first, with the data line sampled on rising serial clock edges while select is low.
- R2: When the direction line is low (write) at the last rising edge of a complete transfer, the addressed register takes the received data byte. No register changes before that edge.
- R3: When the direction line is high (read), the addressed register is returned most significant bit first. Each bit appears after a falling serial clock edge and is valid at the following rising edge.
- R4: The output-enable is high only while select is low, the direction line is high and the full address has been received. It stays low during the address phase and during writes.
- R5: While select is high (inactive), serial clock, data and direction inputs have no effect on any register, and the bit counter returns to zero.
- R6: Raising select before the last bit discards the partial transfer and leaves the addressed register unchanged. The next transfer starts cleanly from bit zero.
- R7: The device reset clears the port state and disables the output, but leaves every register's contents intact.
- R8: Rising edges after the last bit of a transfer, within the same select assertion, are ignored.
- R9: A read transfer leaves the register it reads unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low device reset (port state only) |
| ser_cs_n | input | 1 | Active-low select of the serial port |
| ser_clk | input | 1 | Serial clock, asynchronous, at most half of clk |
| ser_rw | input | 1 | Direction: high = read, low = write |
| ser_din | input | 1 | Data line as seen by the block |
| ser_dout | output | 1 | Read data toward the data line |
| ser_doe | output | 1 | Pad enable for driving the data line |

## Verification
A serial input change is seen by the frame logic three master cycles later: two synchronizer stages plus the edge-detect register. A read bit therefore settles about three cycles after the falling edge that advances it, and a write lands about three cycles after the final rising edge. The bench holds every serial clock half-period for four master cycles, drives on the falling master edge, and samples the data line and its enable just before raising the serial clock. It waits at least eight cycles after a transfer before reading a register back. A full write-then-read sweep over all 256 addresses uses data computed arithmetically from each address.

// File: rtl/sregp_pkg.sv
package sregp_pkg;

   // Edge strobes of the serial clock, valid for one master cycle each.
   typedef struct packed {
      logic rise;
      logic fall;
   } sclk_edge_t;

   // Total number of serial bits in one access.
   function automatic int unsigned frame_bits(input int unsigned a_w,
                                              input int unsigned d_w);
      return a_w + d_w;
   endfunction

endpackage

// File: rtl/sregp_sync.sv
module sregp_sync #(
   parameter int unsigned      WIDTH   = 1,
   parameter int unsigned      STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sregp_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("sregp_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{RST_VAL}};
      end else begin
         chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/sregp_bank.sv
module sregp_bank #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 8,
   parameter bit          PER_ROW  = 1'b1
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
         $error("sregp_bank: ADDR_W out of range 1..10");
      end
   endgenerate

   // Register contents have no reset by design: they survive device resets.
   generate
      if (PER_ROW) begin : g_rows
         logic [DEPTH-1:0][DATA_W-1:0] rows;
         for (genvar i = 0; i < DEPTH; i++) begin : g_row
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
               if (wr_en && (wr_addr == ADDR_W'(i))) begin
                  q <= wr_data;
               end
            end
            assign rows[i] = q;
         end
         assign rd_data = rows[rd_addr];
      end else begin : g_mem
         logic [DATA_W-1:0] mem [DEPTH];
         always_ff @(posedge clk) begin
            if (wr_en) begin
               mem[wr_addr] <= wr_data;
            end
         end
         assign rd_data = mem[rd_addr];
      end
   endgenerate

endmodule

// File: rtl/sregp_frame.sv
module sregp_frame
   import sregp_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned FRAME = frame_bits(ADDR_W, DATA_W),
   localparam int unsigned CNT_W = $clog2(FRAME + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  sclk_edge_t        sedge,
   input  logic              rw_s,
   input  logic              din_s,
   input  logic [DATA_W-1:0] rd_byte,
   output logic [ADDR_W-1:0] addr_q,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic [CNT_W-1:0]  bit_cnt,
   output logic              dout,
   output logic              doe
);

   localparam logic [CNT_W-1:0] C_ADDR_END = CNT_W'(ADDR_W);
   localparam logic [CNT_W-1:0] C_LAST     = CNT_W'(FRAME - 1);
   localparam logic [CNT_W-1:0] C_FULL     = CNT_W'(FRAME);

   generate
      if (DATA_W < 2 || ADDR_W < 2) begin : g_bad_widths
         $error("sregp_frame: ADDR_W and DATA_W must be at least 2");
      end
   endgenerate

   logic [FRAME-1:0]  shreg;
   logic [DATA_W-1:0] rd_sh;
   logic              in_frame;
   logic              data_phase;

   assign in_frame   = (bit_cnt < C_FULL);
   assign data_phase = (bit_cnt >= C_ADDR_END) && in_frame;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         shreg   <= '0;
         addr_q  <= '0;
         rd_sh   <= '0;
      end else if (!cs_act) begin
         bit_cnt <= '0;
      end else begin
         if (sedge.rise && in_frame) begin
            shreg   <= {shreg[FRAME-2:0], din_s};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == C_ADDR_END - 1'b1) begin
               addr_q <= {shreg[ADDR_W-2:0], din_s};
            end
         end
         if (sedge.fall && data_phase) begin
            if (bit_cnt == C_ADDR_END) begin
               rd_sh <= rd_byte;
            end else begin
               rd_sh <= {rd_sh[DATA_W-2:0], 1'b0};
            end
         end
      end
   end

   assign wr_data = {shreg[DATA_W-2:0], din_s};
   assign wr_en   = cs_act && sedge.rise && (bit_cnt == C_LAST) && !rw_s;
   assign doe     = cs_act && rw_s && (bit_cnt >= C_ADDR_END);
   assign dout    = doe ? rd_sh[DATA_W-1] : 1'b0;

endmodule

// File: rtl/sregp_top.sv
module sregp_top
   import sregp_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          PER_ROW     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ser_cs_n,
   input  logic ser_clk,
   input  logic ser_rw,
   input  logic ser_din,
   output logic ser_dout,
   output logic ser_doe
);

   localparam int unsigned FRAME = frame_bits(ADDR_W, DATA_W);
   localparam int unsigned CNT_W = $clog2(FRAME + 1);

   // Synchronized inputs: {cs_n, clk, rw, din}; select resets inactive.
   logic [3:0] raw_in;
   logic [3:0] syn_in;
   logic       cs_s_n;
   logic       sclk_s;
   logic       rw_s;
   logic       din_s;

   assign raw_in = {ser_cs_n, ser_clk, ser_rw, ser_din};

   sregp_sync #(
      .WIDTH   (4),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (4'b1000)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn_in)
   );

   assign {cs_s_n, sclk_s, rw_s, din_s} = syn_in;

   logic       sclk_hist;
   sclk_edge_t sedge;
   logic       cs_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_hist <= 1'b0;
      end else begin
         sclk_hist <= sclk_s;
      end
   end

   assign sedge.rise = sclk_s & ~sclk_hist;
   assign sedge.fall = ~sclk_s & sclk_hist;
   assign cs_act     = ~cs_s_n;

   logic [ADDR_W-1:0] addr_q;
   logic              wr_en;
   logic [DATA_W-1:0] wr_data;
   logic [DATA_W-1:0] rd_byte;
   logic [CNT_W-1:0]  bit_cnt;

   sregp_frame #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_act  (cs_act),
      .sedge   (sedge),
      .rw_s    (rw_s),
      .din_s   (din_s),
      .rd_byte (rd_byte),
      .addr_q  (addr_q),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .bit_cnt (bit_cnt),
      .dout    (ser_dout),
      .doe     (ser_doe)
   );

   sregp_bank #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .PER_ROW (PER_ROW)
   ) u_bank (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (addr_q),
      .wr_data (wr_data),
      .rd_addr (addr_q),
      .rd_data (rd_byte)
   );

endmodule

// File: rtl/sregp_chk.sv
module sregp_chk #(
   parameter int unsigned CNT_W = 5,
   parameter int unsigned FRAME = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_act,
   input logic             rise,
   input logic             fall,
   input logic             rw_s,
   input logic [CNT_W-1:0] bit_cnt,
   input logic             wr_en,
   input logic             dout,
   input logic             doe
);

   localparam logic [CNT_W-1:0] C_FULL = CNT_W'(FRAME);

   // R5: an inactive select leaves the counter at zero one cycle later
   a_r5_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> (bit_cnt == '0));

   // R1: each rising edge inside a frame advances the counter by one
   a_r1_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_act && rise && bit_cnt < C_FULL) |=> (bit_cnt == $past(bit_cnt) + 1'b1));

   // R8: once the frame is complete the counter does not move on
   a_r8_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_act && bit_cnt == C_FULL) |=> (bit_cnt == C_FULL || bit_cnt == '0));

   // R2: a register write completes the frame
   a_r2_write_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (bit_cnt == C_FULL));

   // R4: no drive while writing or with select inactive
   a_r4_no_drive_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!rw_s || !cs_act) |-> !doe);

   // R3: read data moves only after a falling serial clock edge
   a_r3_dout_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (doe && $past(doe) && !$past(fall)) |-> $stable(dout));

endmodule

bind sregp_top sregp_chk #(
   .CNT_W (CNT_W),
   .FRAME (FRAME)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cs_act  (cs_act),
   .rise    (sedge.rise),
   .fall    (sedge.fall),
   .rw_s    (rw_s),
   .bit_cnt (bit_cnt),
   .wr_en   (wr_en),
   .dout    (ser_dout),
   .doe     (ser_doe)
);

// File: tb/sregp_top_tb.sv
module sregp_top_tb;

   localparam int HALF = 4;   // master cycles per serial clock half period

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_cs_n = 1'b1;
   logic ser_clk = 1'b0;
   logic ser_rw = 1'b0;
   logic ser_din = 1'b0;
   logic ser_dout;
   logic ser_doe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   sregp_top u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .ser_cs_n (ser_cs_n),
      .ser_clk  (ser_clk),
      .ser_rw   (ser_rw),
      .ser_din  (ser_din),
      .ser_dout (ser_dout),
      .ser_doe  (ser_doe)
   );

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 37 + 11) & 255);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // One access. nbits bits are clocked (extra bits beyond 16 are ones).
   // use_cs=0 keeps select high the whole time.
   task automatic xfer(input bit rd, input logic [7:0] addr, input logic [7:0] data,
                       input int nbits, input bit use_cs,
                       output logic [7:0] rdata, output bit oe_addr, output bit oe_data);
      logic [15:0] fr;
      fr = {addr, data};
      rdata = '0;
      oe_addr = 1'b0;
      oe_data = 1'b1;
      wait_cyc(1);
      ser_rw = rd;
      ser_cs_n = !use_cs;
      wait_cyc(HALF);
      for (int i = 0; i < nbits; i++) begin
         ser_din = (i < 16) ? fr[15 - i] : 1'b1;
         wait_cyc(HALF);
         if (i < 8) begin
            if (ser_doe) oe_addr = 1'b1;
         end else if (i < 16) begin
            if (!ser_doe) oe_data = 1'b0;
            rdata = {rdata[6:0], ser_dout};
         end
         ser_clk = 1'b1;
         wait_cyc(HALF);
         ser_clk = 1'b0;
      end
      wait_cyc(HALF);
      ser_cs_n = 1'b1;
      ser_rw = 1'b0;
      wait_cyc(2 * HALF);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d, output bit oe_any);
      logic [7:0] rd_unused;
      bit o1, o2;
      xfer(1'b0, a, d, 16, 1'b1, rd_unused, o1, o2);
      oe_any = o1 | (o2 & 1'b0);
      if (o2) oe_any = 1'b1;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d, output bit oe_a, output bit oe_d);
      xfer(1'b1, a, 8'h00, 16, 1'b1, d, oe_a, oe_d);
   endtask

   initial begin
      logic [7:0] got;
      bit oa, od, oe_any;

      wait_cyc(5);
      // R7/R4: reset state
      check(ser_doe == 1'b0, "R4 reset oe", int'(ser_doe), 0);
      rst_n = 1'b1;
      wait_cyc(5);
      check(ser_doe == 1'b0 && ser_dout == 1'b0, "R7 idle after reset",
            int'({ser_doe, ser_dout}), 0);

      // R1/R2/R4: write every register; no drive during writes
      for (int a = 0; a < 256; a++) begin
         wr(8'(a), pat(a), oe_any);
         check(!oe_any, "R4 no drive on write", int'(oe_any), 0);
      end

      // R1/R3/R4: read every register back
      for (int a = 0; a < 256; a++) begin
         rd(8'(a), got, oa, od);
         check(got == pat(a), "R3 read data", int'(got), int'(pat(a)));
         check(!oa && od, "R4 oe window", int'({oa, od}), 1);
      end

      // R5: select inactive, a full write pattern is ignored
      xfer(1'b0, 8'h10, 8'h00, 16, 1'b0, got, oa, od);
      check(!oa && !od, "R5 no drive with select high", int'({oa, od}), 0);
      rd(8'h10, got, oa, od);
      check(got == pat(16), "R5 ignored while deselected", int'(got), int'(pat(16)));

      // R6: aborted write after 12 bits
      xfer(1'b0, 8'h20, ~pat(32), 12, 1'b1, got, oa, od);
      rd(8'h20, got, oa, od);
      check(got == pat(32), "R6 abort discards", int'(got), int'(pat(32)));
      wr(8'h21, 8'h5A, oe_any);
      rd(8'h21, got, oa, od);
      check(got == 8'h5A, "R6 clean restart", int'(got), 'h5A);

      // R8: extra rising edges after bit 16
      xfer(1'b0, 8'h30, 8'hC3, 21, 1'b1, got, oa, od);
      rd(8'h30, got, oa, od);
      check(got == 8'hC3, "R8 extra edges ignored", int'(got), 'hC3);
      rd(8'h31, got, oa, od);
      check(got == pat(49), "R8 neighbour intact", int'(got), int'(pat(49)));

      // R9: repeated reads do not disturb
      rd(8'h40, got, oa, od);
      rd(8'h40, got, oa, od);
      check(got == pat(64), "R9 read is non-destructive", int'(got), int'(pat(64)));

      // R2: a write of zero and of all ones at the address extremes
      wr(8'h00, 8'hFF, oe_any);
      wr(8'hFF, 8'h00, oe_any);
      rd(8'h00, got, oa, od);
      check(got == 8'hFF, "R2 write low address", int'(got), 'hFF);
      rd(8'hFF, got, oa, od);
      check(got == 8'h00, "R2 write high address", int'(got), 0);

      // R7: device reset keeps register contents
      rst_n = 1'b0;
      wait_cyc(3);
      check(ser_doe == 1'b0, "R7 oe low in reset", int'(ser_doe), 0);
      rst_n = 1'b1;
      wait_cyc(3);
      rd(8'h21, got, oa, od);
      check(got == 8'h5A, "R7 contents survive reset", int'(got), 'h5A);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule